// File: doc/BRIEF.md
# Token-Firing Dataflow Expression Unit

This block evaluates Z = (A + B) * (C - D) as a small graph of firing nodes. Each of the four signed operands arrives on its own valid/ready channel, and every transfer carries one token. An adder node joins A with B and a subtractor node joins C with D. Each of the two nodes fires by itself in any cycle in which both of its operands are offered and its result edge can take a token. A multiplier node joins the two intermediate edges. Its product goes into an output slot that drives the Z channel.

Every edge between nodes holds at most one token. A producing node stalls while its edge is full, unless that edge is being emptied in the same cycle. Tokens never pass one another, so the n-th result always belongs to the n-th token of each operand stream. The result is wide enough to hold any product without overflow. A caller streams operand tuples in, with any pattern of gaps on any channel, and takes results whenever it is ready.

Top module: `df_expr_unit`

## Requirements
- R1: Each result equals (A + B) * (C - D), with all operands read as two's-complement values of W bits.
- R2: a_ready stays low while b_valid is low, and b_ready stays low while a_valid is low. The same rule holds for the C/D pair, so no operand is taken without its partner.
- R3: A and B transfer in the same cycle, and C and D transfer in the same cycle. Each firing takes exactly one token from each of its two inputs.
- R4: The A/B pair is accepted while C and D are absent, and the C/D pair is accepted while A and B are absent. The two first-level nodes fire independently.
- R5: Each internal edge holds one token. While the A+B edge is full and is not being drained, a second A/B pair is refused. The pair is accepted in the cycle the multiplier drains that edge.
- R6: While z_valid is high and z_ready is low, z_valid stays high and z_data does not change.
- R7: Under arbitrary stalls on all five channels, results appear in operand order and exactly one result appears per operand tuple.
- R8: z_data is 2W+2 bits wide and is exact at the operand extremes: for W=8, (-128,-128,-128,127) gives 65280 and (127,127,127,-128) gives 64770.
- R9: After reset no result is pending (z_valid is low) and all edges are empty. With all four operands valid, all four readies are high.
- R10: When z_ready is held high, a new tuple is accepted every cycle. Its result shows on z_valid/z_data two clock edges after the operands are accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_valid | input | 1 | Operand A token offered |
| a_ready | output | 1 | Operand A token taken this cycle if valid |
| a_data | input | W | Operand A, signed |
| b_valid | input | 1 | Operand B token offered |
| b_ready | output | 1 | Operand B token taken this cycle if valid |
| b_data | input | W | Operand B, signed |
| c_valid | input | 1 | Operand C token offered |
| c_ready | output | 1 | Operand C token taken this cycle if valid |
| c_data | input | W | Operand C, signed |
| d_valid | input | 1 | Operand D token offered |
| d_ready | output | 1 | Operand D token taken this cycle if valid |
| d_data | input | W | Operand D, signed |
| z_valid | output | 1 | Result token present |
| z_ready | input | 1 | Consumer takes the result this cycle |
| z_data | output | 2W+2 | Result, signed |

## Verification
A wrong internal state shows at the ports within one or two cycles.

- **Edge stuck empty or wrongly full.** An intermediate edge that is stuck empty shows up as a missing result two edges after acceptance. One that wrongly reads full shows up as a first-level ready that stays low, and this is visible in the very next cycle.
- **Lost or doubled token.** This misaligns every later result against the ordered operand queues, so the first wrong value appears at the next output transfer.
- **Overwritten edge.** A token lost this way shows up as an extra A/B acceptance in a cycle where the refusal rule demands a low ready.
- **Faulty output slot.** A slot that changes data under back-pressure is caught in the first held cycle.

// File: rtl/df_pkg.sv
package df_pkg;
  // Operation a join node applies to its two input tokens.
  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_MUL = 2'd2
  } df_op_e;
endpackage

// File: rtl/df_edge_buf.sv
// One-token edge: holds a single token between a producer and a consumer.
module df_edge_buf #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_data
);
  logic             full_q;
  logic [WIDTH-1:0] data_q;
  logic             put_ev;
  logic             take_ev;

  assign take_ev   = full_q & out_ready;
  assign in_ready  = ~full_q | out_ready;
  assign put_ev    = in_valid & in_ready;
  assign out_valid = full_q;
  assign out_data  = data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      if (put_ev) begin
        full_q <= 1'b1;
        data_q <= in_data;
      end else if (take_ev) begin
        full_q <= 1'b0;
      end
    end
  end

  // R6
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R5
  no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready && out_valid && !out_ready));
endmodule

// File: rtl/df_join_node.sv
// Two-input firing node: fires when both inputs hold tokens and the output edge can take one.
module df_join_node
  import df_pkg::*;
#(
  parameter int     IW = 8,
  parameter int     OW = 9,
  parameter df_op_e OP = OP_ADD
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          x_valid,
  output logic          x_ready,
  input  logic [IW-1:0] x_data,
  input  logic          y_valid,
  output logic          y_ready,
  input  logic [IW-1:0] y_data,
  output logic          r_valid,
  input  logic          r_ready,
  output logic [OW-1:0] r_data
);
  logic both_ev;
  logic fire_ev;

  function automatic logic signed [OW-1:0] widen(input logic signed [IW-1:0] v);
    return OW'(v);
  endfunction

  function automatic logic [OW-1:0] add_fn(input logic [IW-1:0] p, input logic [IW-1:0] q);
    return widen(p) + widen(q);
  endfunction

  function automatic logic [OW-1:0] sub_fn(input logic [IW-1:0] p, input logic [IW-1:0] q);
    return widen(p) - widen(q);
  endfunction

  function automatic logic [OW-1:0] mul_fn(input logic [IW-1:0] p, input logic [IW-1:0] q);
    return widen(p) * widen(q);
  endfunction

  generate
    if (OP == OP_ADD) begin : g_add
      assign r_data = add_fn(x_data, y_data);
    end else if (OP == OP_SUB) begin : g_sub
      assign r_data = sub_fn(x_data, y_data);
    end else begin : g_mul
      assign r_data = mul_fn(x_data, y_data);
    end
  endgenerate

  assign both_ev = x_valid & y_valid;
  assign fire_ev = both_ev & r_ready;
  assign r_valid = both_ev;
  assign x_ready = y_valid & r_ready;
  assign y_ready = x_valid & r_ready;

  // R2
  partner_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (x_valid && x_ready) |-> (y_valid && r_ready));

  // R3
  paired_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (x_valid && x_ready) == (y_valid && y_ready));

  // R3
  fire_consumes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_ev |-> (x_ready && y_ready));
endmodule

// File: rtl/df_expr_unit.sv
// Dataflow graph for Z = (A + B) * (C - D) with one-token edges.
module df_expr_unit
  import df_pkg::*;
#(
  parameter int W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             a_valid,
  output logic             a_ready,
  input  logic [W-1:0]     a_data,
  input  logic             b_valid,
  output logic             b_ready,
  input  logic [W-1:0]     b_data,
  input  logic             c_valid,
  output logic             c_ready,
  input  logic [W-1:0]     c_data,
  input  logic             d_valid,
  output logic             d_ready,
  input  logic [W-1:0]     d_data,
  output logic             z_valid,
  input  logic             z_ready,
  output logic [2*W+1:0]   z_data
);
  localparam int MW = W + 1;
  localparam int ZW = 2 * MW;

  // first level -> t1 / t2 edges
  logic          sum_v, sum_rdy;
  logic [MW-1:0] sum_d;
  logic          dif_v, dif_rdy;
  logic [MW-1:0] dif_d;
  // edges -> multiplier
  logic          t1_v, t1_take;
  logic [MW-1:0] t1_d;
  logic          t2_v, t2_take;
  logic [MW-1:0] t2_d;
  // multiplier -> output slot
  logic          prod_v, prod_rdy;
  logic [ZW-1:0] prod_d;

  df_join_node #(.IW(W), .OW(MW), .OP(OP_ADD)) u_add (
    .clk(clk), .rst_n(rst_n),
    .x_valid(a_valid), .x_ready(a_ready), .x_data(a_data),
    .y_valid(b_valid), .y_ready(b_ready), .y_data(b_data),
    .r_valid(sum_v), .r_ready(sum_rdy), .r_data(sum_d)
  );

  df_join_node #(.IW(W), .OW(MW), .OP(OP_SUB)) u_sub (
    .clk(clk), .rst_n(rst_n),
    .x_valid(c_valid), .x_ready(c_ready), .x_data(c_data),
    .y_valid(d_valid), .y_ready(d_ready), .y_data(d_data),
    .r_valid(dif_v), .r_ready(dif_rdy), .r_data(dif_d)
  );

  df_edge_buf #(.WIDTH(MW)) u_t1 (
    .clk(clk), .rst_n(rst_n),
    .in_valid(sum_v), .in_ready(sum_rdy), .in_data(sum_d),
    .out_valid(t1_v), .out_ready(t1_take), .out_data(t1_d)
  );

  df_edge_buf #(.WIDTH(MW)) u_t2 (
    .clk(clk), .rst_n(rst_n),
    .in_valid(dif_v), .in_ready(dif_rdy), .in_data(dif_d),
    .out_valid(t2_v), .out_ready(t2_take), .out_data(t2_d)
  );

  df_join_node #(.IW(MW), .OW(ZW), .OP(OP_MUL)) u_mul (
    .clk(clk), .rst_n(rst_n),
    .x_valid(t1_v), .x_ready(t1_take), .x_data(t1_d),
    .y_valid(t2_v), .y_ready(t2_take), .y_data(t2_d),
    .r_valid(prod_v), .r_ready(prod_rdy), .r_data(prod_d)
  );

  df_edge_buf #(.WIDTH(ZW)) u_zslot (
    .clk(clk), .rst_n(rst_n),
    .in_valid(prod_v), .in_ready(prod_rdy), .in_data(prod_d),
    .out_valid(z_valid), .out_ready(z_ready), .out_data(z_data)
  );

  // R10
  result_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (t1_v && t2_v && (!z_valid || z_ready)) |=> z_valid);
endmodule

// File: tb/df_expr_unit_bench.sv
module df_expr_unit_bench;
  localparam int W = 8;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic a_valid, b_valid, c_valid, d_valid, z_valid, z_ready;
  logic a_ready, b_ready, c_ready, d_ready;
  logic signed [W-1:0] a_data, b_data, c_data, d_data;
  logic signed [2*W+1:0] z_data;

  int errors = 0;
  int checks = 0;
  int zcount = 0;
  bit hs_a, hs_b, hs_c, hs_d;
  longint qa[$], qb[$], qc[$], qd[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  df_expr_unit #(.W(W)) u_df_expr_unit (
    .clk(clk), .rst_n(rst_n),
    .a_valid(a_valid), .a_ready(a_ready), .a_data(a_data),
    .b_valid(b_valid), .b_ready(b_ready), .b_data(b_data),
    .c_valid(c_valid), .c_ready(c_ready), .c_data(c_data),
    .d_valid(d_valid), .d_ready(d_ready), .d_data(d_data),
    .z_valid(z_valid), .z_ready(z_ready), .z_data(z_data)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic longint model(longint a, longint b, longint c, longint d);
    return (a + b) * (c - d);
  endfunction

  // Samples handshakes 3 time units after each falling edge, ahead of the next rising edge.
  always @(negedge clk) begin
    #3;
    hs_a = a_valid && a_ready;
    hs_b = b_valid && b_ready;
    hs_c = c_valid && c_ready;
    hs_d = d_valid && d_ready;
    if (rst_n) begin
      if (hs_a || hs_b) chk(hs_a == hs_b, "R3 A/B paired", longint'(hs_a), longint'(hs_b));
      if (hs_c || hs_d) chk(hs_c == hs_d, "R3 C/D paired", longint'(hs_c), longint'(hs_d));
    end
    if (hs_a) qa.push_back(longint'(a_data));
    if (hs_b) qb.push_back(longint'(b_data));
    if (hs_c) qc.push_back(longint'(c_data));
    if (hs_d) qd.push_back(longint'(d_data));
    if (rst_n && z_valid && z_ready) begin
      if (qa.size() == 0 || qb.size() == 0 || qc.size() == 0 || qd.size() == 0) begin
        chk(1'b0, "R7 result without operands", longint'(z_data), 0);
      end else begin
        longint e;
        e = model(qa.pop_front(), qb.pop_front(), qc.pop_front(), qd.pop_front());
        chk(longint'(z_data) == e, "R1 R7 R8 result value", longint'(z_data), e);
      end
      zcount++;
    end
  end

  task automatic drop_all();
    a_valid = 0; b_valid = 0; c_valid = 0; d_valid = 0;
  endtask

  task automatic t_reset();
    rst_n = 0; drop_all(); z_ready = 0;
    a_data = 0; b_data = 0; c_data = 0; d_data = 0;
    repeat (3) @(negedge clk);
    #3 chk(z_valid == 0, "R9 z_valid low in reset", longint'(z_valid), 0);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    a_valid = 1; a_data = 1; b_valid = 1; b_data = 2;
    c_valid = 1; c_data = 3; d_valid = 1; d_data = 4;
    #3;
    chk(z_valid == 0, "R9 nothing pending", longint'(z_valid), 0);
    chk(a_ready && b_ready && c_ready && d_ready, "R9 empty edges accept",
        longint'({a_ready, b_ready, c_ready, d_ready}), 15);
    @(negedge clk); drop_all();
    @(negedge clk);
    #3 chk(z_valid && longint'(z_data) == -3, "R1 first result", longint'(z_data), -3);
    z_ready = 1;
    @(negedge clk);
    #3 chk(z_valid == 0, "R9 slot empties", longint'(z_valid), 0);
  endtask

  task automatic t_lone();
    @(negedge clk);
    z_ready = 1;
    a_valid = 1; a_data = -5; b_valid = 0;
    c_valid = 1; c_data = 7; d_valid = 1; d_data = -3;
    #3;
    chk(a_ready == 0, "R2 A waits for B", longint'(a_ready), 0);
    chk(c_ready == 1, "R4 C/D fire alone", longint'(c_ready), 1);
    @(negedge clk); c_valid = 0; d_valid = 0;
    #3 chk(a_ready == 0, "R2 A still waits", longint'(a_ready), 0);
    chk(d_ready == 0, "R2 D waits for C", longint'(d_ready), 0);
    @(negedge clk); b_valid = 1; b_data = 6;
    #3 chk(a_ready && b_ready, "R2 pair completes", longint'({a_ready, b_ready}), 3);
    @(negedge clk); drop_all();
    @(negedge clk);
    #3 chk(z_valid && longint'(z_data) == 10, "R1 mixed sign", longint'(z_data), 10);
    @(negedge clk);
  endtask

  task automatic t_partial();
    @(negedge clk);
    z_ready = 0;
    a_valid = 1; a_data = 3; b_valid = 1; b_data = 4;
    #3 chk(a_ready && b_ready, "R4 A/B fire alone", longint'({a_ready, b_ready}), 3);
    @(negedge clk); a_data = 10; b_data = 20;
    #3 chk(a_ready == 0, "R5 full edge refuses", longint'(a_ready), 0);
    chk(z_valid == 0, "R2 no result without C/D", longint'(z_valid), 0);
    @(negedge clk); c_valid = 1; c_data = 9; d_valid = 1; d_data = 2;
    #3 chk(c_ready == 1, "R4 C/D accepted", longint'(c_ready), 1);
    chk(a_ready == 0, "R5 still refused", longint'(a_ready), 0);
    @(negedge clk); c_data = 5; d_data = 1;
    #3 chk(a_ready == 1, "R5 accepted on drain", longint'(a_ready), 1);
    chk(c_ready == 1, "R5 C accepted on drain", longint'(c_ready), 1);
    @(negedge clk); drop_all();
    #3 chk(z_valid && longint'(z_data) == 49, "R1 held result", longint'(z_data), 49);
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      #3 chk(z_valid && longint'(z_data) == 49, "R6 hold under stall", longint'(z_data), 49);
    end
    @(negedge clk); z_ready = 1;
    @(negedge clk);
    #3 chk(z_valid && longint'(z_data) == 120, "R1 second result", longint'(z_data), 120);
    @(negedge clk);
    #3 chk(z_valid == 0, "R7 no extra result", longint'(z_valid), 0);
  endtask

  task automatic t_fullrate();
    longint ta[6] = '{-128, 127, 5, -1, 100, -7};
    longint tb[6] = '{-128, 127, -9, -1, 27, 3};
    longint tc[6] = '{-128, 127, 64, 0, -50, 11};
    longint td[6] = '{127, -128, -64, 0, 77, 12};
    longint ex[6];
    for (int i = 0; i < 6; i++) ex[i] = model(ta[i], tb[i], tc[i], td[i]);
    chk(ex[0] == 65280, "R8 bench model extreme", ex[0], 65280);
    z_ready = 1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (i < 6) begin
        a_valid = 1; a_data = W'(ta[i]); b_valid = 1; b_data = W'(tb[i]);
        c_valid = 1; c_data = W'(tc[i]); d_valid = 1; d_data = W'(td[i]);
      end else begin
        drop_all();
      end
      #3;
      if (i < 6) chk(a_ready && b_ready && c_ready && d_ready, "R10 accept every cycle",
                     longint'({a_ready, b_ready, c_ready, d_ready}), 15);
      if (i >= 2) chk(z_valid && longint'(z_data) == ex[i-2], "R10 R8 two-edge latency",
                      longint'(z_data), ex[i-2]);
    end
    @(negedge clk);
  endtask

  task automatic t_stream(input int n, input int stall);
    int sa = 0, sb = 0, sc = 0, sd = 0, cyc = 0;
    int base = zcount;
    while ((zcount - base) < n && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (a_valid && hs_a) begin sa++; a_valid = 0; end
      if (b_valid && hs_b) begin sb++; b_valid = 0; end
      if (c_valid && hs_c) begin sc++; c_valid = 0; end
      if (d_valid && hs_d) begin sd++; d_valid = 0; end
      if (!a_valid && sa < n && ($urandom % 100) >= stall) begin a_valid = 1; a_data = W'($urandom); end
      if (!b_valid && sb < n && ($urandom % 100) >= stall) begin b_valid = 1; b_data = W'($urandom); end
      if (!c_valid && sc < n && ($urandom % 100) >= stall) begin c_valid = 1; c_data = W'($urandom); end
      if (!d_valid && sd < n && ($urandom % 100) >= stall) begin d_valid = 1; d_data = W'($urandom); end
      z_ready = (($urandom % 100) >= stall);
    end
    drop_all();
    z_ready = 1;
    repeat (3) @(negedge clk);
    chk((zcount - base) == n, "R7 one result per tuple", longint'(zcount - base), longint'(n));
    chk(qa.size() == 0 && qc.size() == 0, "R7 no leftover operands",
        longint'(qa.size() + qc.size()), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_lone();
    t_partial();
    t_fullrate();
    t_stream(300, 40);
    t_stream(300, 10);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule